// File: doc/BRIEF.md
# Indexed Pixel Colorizer With Split Palettes

This block sits beside a video display processor whose own palette is bypassed. Each pixel clock enable delivers a packed pixel byte. The byte holds a 4-bit colour index, a 2-bit palette number, a layer flag and an effect flag. The block decodes the byte and reads a 12-bit colour from one of two 64-entry banks: one bank serves the background planes and the other serves sprites. It then applies one of three brightness treatments and registers the result as digital RGB with 6 bits per channel. Because of the wider output, the dimmed and brightened levels land on steps that the 4-bit stored channels cannot express.

A host loads the colour RAM through a simple strobe write port. A control input chooses between split palettes and a single shared plane palette. A blanking input forces black on the pixels it covers. A highlight input works together with the effect flag in the pixel byte to pick one of the three brightness states.

Top module: `pal_colorizer`

## Requirements
- R1: The pixel byte addresses an entry in a bank through its colour index in bits 3..0 and its palette number in bits 5..4. The entry address inside the bank is {palette, index}.
- R2: When `split_en` is 1, pixel byte bit 6 selects the bank: 1 reads the sprite bank and 0 reads the plane bank.
- R3: When `split_en` is 0, every pixel reads the plane bank and pixel byte bit 6 has no effect.
- R4: The write port loads one entry on `wr_en`. The entry is chosen as follows: `wr_addr` bit 6 picks the bank (1 = sprite), bits 5..4 give the palette and bits 3..0 give the index. The stored colour takes red from `wr_data` bits 3..0, green from bits 7..4 and blue from bits 11..8. Bits 15..12 of `wr_data` are ignored.
- R5: At normal brightness, each 4-bit channel c is output as {c,2'b00}.
- R6: In shadow (pixel byte bit 7 = 1, `hilite` = 0), each channel is output as {1'b0,c,1'b0}.
- R7: In highlight (pixel byte bit 7 = 0, `hilite` = 1), each channel is output as {1'b0,c,1'b0} + 30, saturating at 63.
- R8: When pixel byte bit 7 and `hilite` are both 1, or both 0, the brightness is normal.
- R9: `out_valid` and the RGB value for a pixel appear two clock edges after the edge that samples `pix_en` high. `out_valid` is 0 at the first of those two edges if the previous cycle was idle.
- R10: A pixel sampled with `blank` = 1 is output as black (all channels 0), and `out_valid` stays 1.
- R11: When a write and a pixel read hit the same entry in the same cycle, the pixel returns the value held before the write. Later reads return the new value.
- R12: While `out_valid` is 0, all three channels are 0. Reset clears `out_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel-domain clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_en | input | 1 | Pixel clock enable; samples `pix_byte` |
| pix_byte | input | 8 | Packed effect / layer / palette / index byte |
| hilite | input | 1 | Highlight request, combined with byte bit 7 |
| blank | input | 1 | Forces this pixel to black |
| split_en | input | 1 | 1 = separate sprite bank, 0 = plane bank only |
| wr_en | input | 1 | Colour RAM write strobe |
| wr_addr | input | 7 | Bank, palette and index of the entry to write |
| wr_data | input | 16 | Packed colour word; top nibble ignored |
| out_valid | output | 1 | RGB holds a pixel |
| red | output | 6 | Red channel |
| grn | output | 6 | Green channel |
| blu | output | 6 | Blue channel |

## Verification
On every cycle, the assertions check the two-edge alignment of `out_valid` with `pix_en`, the black output while blanking or idle, and the bit patterns that each brightness state must produce: low bits clear at normal, top and bottom bits clear in shadow, and a floor of 30 in highlight. The assertions cannot see which entry was read. Only the bench scenarios can show the address decode, the bank choice with and without split palettes, the packing of channels in the write word, and the old value returned on a read-during-write. They do so by comparing exact RGB values against a model of the bank contents that the bench keeps itself.

// File: rtl/pcz_pkg.sv
package pcz_pkg;
   typedef enum logic [1:0] {
      FX_NORM = 2'd0,
      FX_SHAD = 2'd1,
      FX_HIGH = 2'd2
   } fx_e;

   // effect flag from the pixel byte and the external highlight request
   function automatic fx_e fx_pick(input logic fx_flag, input logic hl);
      if (fx_flag && !hl)      return FX_SHAD;
      else if (!fx_flag && hl) return FX_HIGH;
      else                     return FX_NORM;
   endfunction
endpackage

// File: rtl/pcz_decode.sv
module pcz_decode
   import pcz_pkg::*;
#(
   parameter int IDX_W = 4,
   parameter int PAL_W = 2,
   localparam int PIX_W = IDX_W + PAL_W + 2,
   localparam int AW    = IDX_W + PAL_W + 1
) (
   input  logic [PIX_W-1:0] pix_byte,
   input  logic             hilite,
   input  logic             split_en,
   output logic [AW-1:0]    rd_addr,
   output fx_e              fx
);
   localparam int LAYER_BIT = IDX_W + PAL_W;
   localparam int FX_BIT    = IDX_W + PAL_W + 1;

   logic sprite_bank;

   always_comb begin
      sprite_bank = split_en & pix_byte[LAYER_BIT];
      rd_addr     = {sprite_bank, pix_byte[LAYER_BIT-1:0]};
      fx          = fx_pick(pix_byte[FX_BIT], hilite);
   end
endmodule

// File: rtl/pcz_cram.sv
module pcz_cram #(
   parameter int AW   = 7,
   parameter int CH_W = 4,
   localparam int DEPTH = 1 << AW,
   localparam int CW    = 3 * CH_W
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [CW-1:0] wdata,
   input  logic          re,
   input  logic [AW-1:0] raddr,
   output logic [CW-1:0] rdata
);
   logic [CW-1:0] mem [DEPTH];

   // a read of the entry under write sees the value from before this edge
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      if (re) rdata <= mem[raddr];
   end
endmodule

// File: rtl/pcz_shade.sv
module pcz_shade
   import pcz_pkg::*;
#(
   parameter int CH_W  = 4,
   parameter int OUT_W = 6,
   localparam int CW     = 3 * CH_W,
   localparam int OW     = 3 * OUT_W,
   localparam int PAD_N  = OUT_W - CH_W,
   localparam int PAD_S  = OUT_W - CH_W - 1,
   localparam int HL_OFS = (1 << (OUT_W - 1)) - 2,
   localparam int MAXV   = (1 << OUT_W) - 1
) (
   input  fx_e           fx,
   input  logic [CW-1:0] color,
   output logic [OW-1:0] rgb
);
   if (OUT_W < CH_W + 2) begin : g_bad_width
      $error("pcz_shade: OUT_W must exceed CH_W by at least 2");
   end

   for (genvar ch = 0; ch < 3; ch++) begin : g_ch
      logic [CH_W-1:0]  c;
      logic [OUT_W-1:0] v_norm, v_shad;
      logic [OUT_W:0]   v_sum;
      logic [OUT_W-1:0] v_high;

      always_comb begin
         c      = color[ch*CH_W +: CH_W];
         v_norm = {c, {PAD_N{1'b0}}};
         v_shad = {1'b0, c, {PAD_S{1'b0}}};
         v_sum  = {1'b0, v_shad} + (OUT_W+1)'(HL_OFS);
         v_high = (v_sum > (OUT_W+1)'(MAXV)) ? OUT_W'(MAXV) : v_sum[OUT_W-1:0];
         unique case (fx)
            FX_SHAD: rgb[ch*OUT_W +: OUT_W] = v_shad;
            FX_HIGH: rgb[ch*OUT_W +: OUT_W] = v_high;
            default: rgb[ch*OUT_W +: OUT_W] = v_norm;
         endcase
      end
   end
endmodule

// File: rtl/pal_colorizer.sv
module pal_colorizer
   import pcz_pkg::*;
#(
   parameter int IDX_W  = 4,
   parameter int PAL_W  = 2,
   parameter int CH_W   = 4,
   parameter int OUT_W  = 6,
   parameter int WD_W   = 16,
   localparam int PIX_W = IDX_W + PAL_W + 2,
   localparam int AW    = IDX_W + PAL_W + 1,
   localparam int CW    = 3 * CH_W
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pix_en,
   input  logic [PIX_W-1:0] pix_byte,
   input  logic             hilite,
   input  logic             blank,
   input  logic             split_en,
   input  logic             wr_en,
   input  logic [AW-1:0]    wr_addr,
   input  logic [WD_W-1:0]  wr_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] red,
   output logic [OUT_W-1:0] grn,
   output logic [OUT_W-1:0] blu
);
   if (WD_W < CW) begin : g_bad_wd
      $error("pal_colorizer: write word narrower than a colour entry");
   end

   logic [AW-1:0]    rd_addr;
   fx_e              fx_d, s1_fx;
   logic             s1_vld, s1_blank;
   logic [CW-1:0]    s1_color;
   logic [3*OUT_W-1:0] shaded;

   // top nibble of the write word carries nothing
   logic unused_wd_hi;
   if (WD_W > CW) begin : g_wd_hi
      assign unused_wd_hi = ^wr_data[WD_W-1:CW];
   end else begin : g_wd_exact
      assign unused_wd_hi = 1'b0;
   end

   pcz_decode #(.IDX_W(IDX_W), .PAL_W(PAL_W)) u_dec (
      .pix_byte (pix_byte),
      .hilite   (hilite),
      .split_en (split_en),
      .rd_addr  (rd_addr),
      .fx       (fx_d)
   );

   pcz_cram #(.AW(AW), .CH_W(CH_W)) u_ram (
      .clk   (clk),
      .we    (wr_en),
      .waddr (wr_addr),
      .wdata (wr_data[CW-1:0]),
      .re    (pix_en),
      .raddr (rd_addr),
      .rdata (s1_color)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         s1_vld   <= 1'b0;
         s1_blank <= 1'b0;
         s1_fx    <= FX_NORM;
      end else begin
         s1_vld   <= pix_en;
         s1_blank <= blank;
         s1_fx    <= fx_d;
      end
   end

   pcz_shade #(.CH_W(CH_W), .OUT_W(OUT_W)) u_shd (
      .fx    (s1_fx),
      .color (s1_color),
      .rgb   (shaded)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         red       <= '0;
         grn       <= '0;
         blu       <= '0;
      end else begin
         out_valid <= s1_vld;
         if (s1_vld && !s1_blank) begin
            red <= shaded[0*OUT_W +: OUT_W];
            grn <= shaded[1*OUT_W +: OUT_W];
            blu <= shaded[2*OUT_W +: OUT_W];
         end else begin
            red <= '0;
            grn <= '0;
            blu <= '0;
         end
      end
   end
endmodule

// File: rtl/pcz_chk.sv
module pcz_chk #(
   parameter int PIX_W = 8,
   parameter int OUT_W = 6,
   localparam int HL_OFS = (1 << (OUT_W - 1)) - 2
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pix_en,
   input logic [PIX_W-1:0] pix_byte,
   input logic             hilite,
   input logic             blank,
   input logic             out_valid,
   input logic [OUT_W-1:0] red,
   input logic [OUT_W-1:0] grn,
   input logic [OUT_W-1:0] blu
);
   localparam int FXB = PIX_W - 1;

   a_r9_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      pix_en |=> ##1 out_valid);
   a_r9_idle_follows: assert property (@(posedge clk) disable iff (!rst_n)
      !pix_en |=> ##1 !out_valid);
   a_r10_blank_black: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && blank) |=> ##1 (red == '0 && grn == '0 && blu == '0));
   a_r12_idle_black: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (red == '0 && grn == '0 && blu == '0));
   a_r6_shadow_form: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !blank && pix_byte[FXB] && !hilite) |=> ##1
      (!red[OUT_W-1] && !red[0] && !grn[OUT_W-1] && !grn[0] && !blu[OUT_W-1] && !blu[0]));
   a_r7_high_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !blank && !pix_byte[FXB] && hilite) |=> ##1
      (red >= OUT_W'(HL_OFS) && grn >= OUT_W'(HL_OFS) && blu >= OUT_W'(HL_OFS)));
   a_r8_normal_form: assert property (@(posedge clk) disable iff (!rst_n)
      (pix_en && !blank && (pix_byte[FXB] == hilite)) |=> ##1
      (red[1:0] == 2'b00 && grn[1:0] == 2'b00 && blu[1:0] == 2'b00));
endmodule

bind pal_colorizer pcz_chk #(.PIX_W(PIX_W), .OUT_W(OUT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .pix_en    (pix_en),
   .pix_byte  (pix_byte),
   .hilite    (hilite),
   .blank     (blank),
   .out_valid (out_valid),
   .red       (red),
   .grn       (grn),
   .blu       (blu)
);

// File: tb/sim_pal_colorizer.sv
`timescale 1ns/1ps
module sim_pal_colorizer;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pix_en = 1'b0;
   logic [7:0] pix_byte = '0;
   logic       hilite = 1'b0;
   logic       blank = 1'b0;
   logic       split_en = 1'b0;
   logic       wr_en = 1'b0;
   logic [6:0] wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic       out_valid;
   logic [5:0] red, grn, blu;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;
   logic [11:0] model [128];

   always #2.5 clk = ~clk;

   pal_colorizer u0 (.*);

   task automatic check(input bit ok, input string req, input logic [17:0] act, input logic [17:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   function automatic logic [5:0] shade_ch(input logic [3:0] c, input logic fxf, input logic hl);
      logic [6:0] s;
      if (fxf && !hl) return {1'b0, c, 1'b0};
      if (!fxf && hl) begin
         s = {2'b00, c, 1'b0} + 7'd30;
         return (s > 7'd63) ? 6'd63 : s[5:0];
      end
      return {c, 2'b00};
   endfunction

   function automatic logic [17:0] expect_rgb(input logic [7:0] pb, input logic hl, input logic bl, input logic sp);
      logic [11:0] e;
      if (bl) return '0;
      e = model[{sp & pb[6], pb[5:0]}];
      return {shade_ch(e[11:8], pb[7], hl), shade_ch(e[7:4], pb[7], hl), shade_ch(e[3:0], pb[7], hl)};
   endfunction

   task automatic write_entry(input logic [6:0] a, input logic [15:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(posedge clk); #1;
      wr_en = 1'b0;
      model[a] = d[11:0];
   endtask

   // one pixel through the pipe, checking both edges of its latency
   task automatic run_pix(input logic [7:0] pb, input logic hl, input logic bl, input logic sp, input string req);
      logic [17:0] exp;
      exp = expect_rgb(pb, hl, bl, sp);
      @(negedge clk);
      pix_en = 1'b1; pix_byte = pb; hilite = hl; blank = bl; split_en = sp;
      @(posedge clk); #1;
      pix_en = 1'b0; blank = 1'b0; hilite = 1'b0;
      check(out_valid == 1'b0, "R9 early", {17'd0, out_valid}, 18'd0);
      @(posedge clk); #1;
      check(out_valid == 1'b1, "R9 valid", {17'd0, out_valid}, 18'd1);
      check({blu, grn, red} == exp, req, {blu, grn, red}, exp);
   endtask

   task automatic t_reset();
      check(out_valid == 1'b0 && {blu, grn, red} == '0, "R12 reset", {blu, grn, red}, 18'd0);
   endtask

   task automatic t_load();
      for (int i = 0; i < 128; i++)
         write_entry(7'(i), {4'hA, 12'((i * 97 + 5) ^ (i << 6))});
      // R4: high nibble set on an entry must not show
      write_entry(7'h05, 16'hF3C9);
   endtask

   task automatic t_decode();
      run_pix(8'h05, 1'b0, 1'b0, 1'b0, "R4 R1 packing");
      run_pix(8'h2B, 1'b0, 1'b0, 1'b0, "R1 pal2 idx11");
      run_pix(8'h3F, 1'b0, 1'b0, 1'b0, "R1 last entry");
      run_pix(8'h10, 1'b0, 1'b0, 1'b0, "R1 pal1 idx0");
   endtask

   task automatic t_banks();
      run_pix(8'h47, 1'b0, 1'b0, 1'b1, "R2 sprite bank");
      run_pix(8'h07, 1'b0, 1'b0, 1'b1, "R2 plane bank");
      run_pix(8'h7E, 1'b0, 1'b0, 1'b1, "R2 sprite last");
      run_pix(8'h47, 1'b0, 1'b0, 1'b0, "R3 split off");
      run_pix(8'h7E, 1'b0, 1'b0, 1'b0, "R3 split off b");
   endtask

   task automatic t_effects();
      write_entry(7'h01, 16'h0F0F);
      write_entry(7'h41, 16'h00F0);
      run_pix(8'h01, 1'b0, 1'b0, 1'b0, "R5 normal");
      run_pix(8'h81, 1'b0, 1'b0, 1'b0, "R6 shadow");
      run_pix(8'h01, 1'b1, 1'b0, 1'b0, "R7 highlight");
      run_pix(8'h81, 1'b1, 1'b0, 1'b0, "R8 both normal");
      run_pix(8'hC1, 1'b0, 1'b0, 1'b1, "R6 sprite shadow");
      run_pix(8'h41, 1'b1, 1'b0, 1'b1, "R7 sprite highlight");
      // hand-written values for a full-scale channel
      run_pix(8'h01, 1'b1, 1'b0, 1'b0, "R7 full");
      check(red == 6'd60 && grn == 6'd30, "R7 full literal", {6'd0, grn, red}, {6'd0, 6'd30, 6'd60});
   endtask

   task automatic t_blank();
      run_pix(8'h2B, 1'b0, 1'b1, 1'b0, "R10 blank");
      run_pix(8'h01, 1'b1, 1'b1, 1'b1, "R10 blank hl");
   endtask

   task automatic t_idle();
      @(posedge clk); #1;
      check(out_valid == 1'b0 && {blu, grn, red} == '0, "R12 idle", {blu, grn, red}, 18'd0);
   endtask

   task automatic t_rdw();
      logic [17:0] exp_old, exp_new;
      write_entry(7'h1A, 16'h0123);
      exp_old = expect_rgb(8'h1A, 1'b0, 1'b0, 1'b0);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 7'h1A; wr_data = 16'h0ABC;
      pix_en = 1'b1; pix_byte = 8'h1A; split_en = 1'b0;
      @(posedge clk); #1;
      wr_en = 1'b0; pix_en = 1'b0;
      model[7'h1A] = 12'hABC;
      @(posedge clk); #1;
      check({blu, grn, red} == exp_old, "R11 old value", {blu, grn, red}, exp_old);
      exp_new = expect_rgb(8'h1A, 1'b0, 1'b0, 1'b0);
      run_pix(8'h1A, 1'b0, 1'b0, 1'b0, "R11 new value");
      check(exp_new != exp_old, "R11 distinct", exp_new, exp_old);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1 t_reset();
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_load();
      t_decode();
      t_banks();
      t_effects();
      t_blank();
      t_idle();
      t_rdw();
      t_idle();
      finish_run();
   end

   initial begin
      #(200000 * 5);
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end
endmodule